// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the programmable state of one DMA channel behind a small host register bus. Software programs a start address, a descriptor pointer, element counts and strides for two dimensions, and a peripheral routing word. It then writes the control word to launch or halt the channel. The block itself moves no data. It gives the transfer engine a one-cycle start or stop pulse together with the live control word, and it records completion and error events that the engine reports.

While the channel runs, host writes to the transfer parameters are discarded without any error, so the engine always works on a stable parameter set. The control word and the status word stay writable at all times. Status flags clear when software writes a 1 to them. One routing bit describes the channel type; it is fixed after reset and never taken from write data.

Each request lasts one cycle and is marked by `bus_wr` or `bus_rd`. `bus_size` carries the access width in bytes. The response (`bus_rdata`, `bus_err`) is registered and valid in the cycle after the request.

Top module: `dmareg_chan`

## Requirements
- R1: After reset all parameter and current-state slots read 0, the routing word reads 0x0040, status reads 0, `cfg_o` is 0, `run_o`, `start_o`, `stop_o`, `bus_err` are 0 and `bus_rdata` is 0.
- R2: A request whose `bus_size` is not 2 or 4, or whose offset has either of its two low bits set, gives `bus_err`=1 and `bus_rdata`=0 in the next cycle and changes no state, whatever the offset.
- R3: A 2- or 4-byte read is accepted at every slot 0x00..0x3C, including unmapped ones, which read 0. A 2-byte read returns the low 16 bits of the slot, zero-extended.
- R4: A write to the unmapped slots 0x0C, 0x34 or 0x3C gives `bus_err`=1 and changes nothing.
- R5: Slot map: 0x00 next descriptor pointer (32 bits), 0x04 start address (32), 0x08 control (16), 0x10 X count, 0x14 X stride, 0x18 Y count, 0x1C Y stride, 0x20 current descriptor pointer (32), 0x24 current address (32), 0x28 status, 0x2C routing word, 0x30 current X count, 0x38 current Y count. The 16-bit slots store bits 15:0 of the write data.
- R6: While RUN is set, writes to every slot except control and status are discarded with `bus_err`=0. Once RUN clears, these slots are writable again.
- R7: A 2-byte write to a 32-bit slot replaces bits 15:0 and keeps bits 31:16. A 4-byte write replaces all 32 bits.
- R8: Status reads as bit 0 DONE, bit 1 ERR, bit 2 RUN, all other bits 0. A status write clears DONE and ERR where the write data has a 1 in bit 0 or bit 1. It never changes RUN.
- R9: A routing-word write takes bits 15:7 and 5:0 from the write data and keeps the current bit 6. Bit 6 resets to 1.
- R10: A control write with bit 0 set sets RUN and gives `start_o`=1 for exactly the one cycle after the write. This also applies while the channel is already running.
- R11: A control write with bit 0 clear clears RUN and gives `stop_o`=1 for exactly one cycle. Control writes are accepted while running, and `cfg_o` shows the stored control word.
- R12: An `eng_done` pulse sets DONE and clears RUN, unless a control write arrives in the same cycle, in which case the control write decides RUN. An `eng_err` pulse sets ERR. A set wins over a same-cycle write-1-to-clear.
- R13: 4-byte reads of the two stride slots return the stored 16 bits sign-extended to 32 bits. All other 16-bit slots read zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the request |
| bus_wr | input | 1 | Write request, one cycle |
| bus_rd | input | 1 | Read request, one cycle (ignored when bus_wr is high) |
| bus_size | input | 3 | Access width in bytes; 2 and 4 are legal |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Request rejected, registered |
| eng_done | input | 1 | Engine finished the transfer |
| eng_err | input | 1 | Engine hit an error |
| cfg_o | output | 16 | Stored control word |
| run_o | output | 1 | Channel running |
| start_o | output | 1 | One-cycle launch pulse |
| stop_o | output | 1 | One-cycle halt pulse |

## Verification
The assertions assume that `eng_done` and `eng_err` are single-cycle pulses. They also assume that the address, size and data are steady for the one cycle in which `bus_wr` or `bus_rd` is high. The bench drives every request for exactly one cycle, with both strobes low in between. It raises the engine pulses only for one cycle, either alongside a bus request or on their own. The protected-write and write-1-to-clear cases are each run with RUN both set and clear. Each such request is followed by a read that brings the stored value back out through the bus.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int unsigned SLOT_CFG  = 2;
  localparam int unsigned SLOT_XCNT = 4;
  localparam int unsigned SLOT_STRT = 1;
  localparam int unsigned SLOT_STAT = 10;
  localparam int unsigned SLOT_PMAP = 11;

  localparam int unsigned STAT_DONE = 0;
  localparam int unsigned STAT_ERR  = 1;
  localparam int unsigned STAT_RUN  = 2;

  localparam int unsigned CFG_EN = 0;

  typedef enum logic [2:0] {
    K_RSVD, K_PTR, K_HALF, K_CFG, K_STAT, K_PMAP
  } kind_t;

  function automatic kind_t slot_kind(input int unsigned s);
    case (s)
      0, 1, 8, 9:             return K_PTR;
      4, 5, 6, 7, 12, 14:     return K_HALF;
      2:                      return K_CFG;
      10:                     return K_STAT;
      11:                     return K_PMAP;
      default:                return K_RSVD;
    endcase
  endfunction

  function automatic logic slot_signed(input int unsigned s);
    return (s == 5) || (s == 7);
  endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int SLOT_W = ADDR_W - 2,
  localparam int NSLOT  = 1 << SLOT_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [2:0]        size,
  output logic [SLOT_W-1:0] slot,
  output logic [NSLOT-1:0]  sel,
  output logic              rd_ok,
  output logic              half,
  output logic              bad
);

  logic size_ok;
  logic mapped;
  logic wr_ok;

  always_comb begin
    slot    = addr[ADDR_W-1:2];
    size_ok = ((size == 3'd2) || (size == 3'd4)) && (addr[1:0] == 2'b00);
    half    = (size == 3'd2);
    mapped  = (slot_kind(32'(slot)) != K_RSVD);
    wr_ok   = wr && size_ok && mapped;
    rd_ok   = rd && !wr && size_ok;
    bad     = ((wr || rd) && !size_ok) || (wr && size_ok && !mapped);
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_sel
    assign sel[i] = wr_ok && (slot == SLOT_W'(i));
  end

endmodule

// File: rtl/dmareg_half.sv
module dmareg_half #(
  parameter int          W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_d;
  end

endmodule

// File: rtl/dmareg_status.sv
module dmareg_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  input  logic       stat_wr,
  input  logic [1:0] clr,
  input  logic       eng_done,
  input  logic       eng_err,
  output logic       run,
  output logic       done,
  output logic       err,
  output logic       start,
  output logic       stop
);

  logic run_d, done_d, err_d, start_d, stop_d;

  always_comb begin
    run_d = run;
    if (cfg_wr)        run_d = cfg_en;
    else if (eng_done) run_d = 1'b0;
    done_d  = eng_done | (done & ~(stat_wr & clr[0]));
    err_d   = eng_err  | (err  & ~(stat_wr & clr[1]));
    start_d = cfg_wr & cfg_en;
    stop_d  = cfg_wr & ~cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      start <= 1'b0;
      stop  <= 1'b0;
    end else begin
      run   <= run_d;
      done  <= done_d;
      err   <= err_d;
      start <= start_d;
      stop  <= stop_d;
    end
  end

  p_cfg_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_en |=> run && start);
  p_cfg_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_en |=> !run && stop);
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && stop));
  p_w1c_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && clr[0] && !eng_done |=> !done);
  p_run_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && !cfg_wr && !eng_done |=> run == $past(run));
  p_eng_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done);

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter logic [15:0] PMAP_RESET = 16'h0040,
  parameter int          CTYPE_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic [15:0]       cfg_o,
  output logic              run_o,
  output logic              start_o,
  output logic              stop_o
);

  localparam int SLOT_W = ADDR_W - 2;
  localparam int NSLOT  = 1 << SLOT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [SLOT_W-1:0] slot;
  logic [NSLOT-1:0]  sel;
  logic              rd_ok, half, bad;

  dmareg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .size (bus_size),
    .slot (slot),
    .sel  (sel),
    .rd_ok(rd_ok),
    .half (half),
    .bad  (bad)
  );

  logic st_done, st_err;

  dmareg_status u_stat (
    .clk     (clk),
    .rst_n   (rst_ni),
    .cfg_wr  (sel[SLOT_CFG]),
    .cfg_en  (bus_wdata[CFG_EN]),
    .stat_wr (sel[SLOT_STAT]),
    .clr     ({bus_wdata[STAT_ERR], bus_wdata[STAT_DONE]}),
    .eng_done(eng_done),
    .eng_err (eng_err),
    .run     (run_o),
    .done    (st_done),
    .err     (st_err),
    .start   (start_o),
    .stop    (stop_o)
  );

  logic [31:0] stat_vec;
  always_comb begin
    stat_vec            = '0;
    stat_vec[STAT_DONE] = st_done;
    stat_vec[STAT_ERR]  = st_err;
    stat_vec[STAT_RUN]  = run_o;
  end

  logic [31:0] view [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (slot_kind(i) == K_PTR) begin : g_ptr
      logic [15:0] lo, hi;
      dmareg_half #(.W(16), .RST(16'h0)) u_lo (
        .clk(clk), .rst_n(rst_ni), .we(sel[i] && !run_o),
        .d(bus_wdata[15:0]), .q(lo));
      dmareg_half #(.W(16), .RST(16'h0)) u_hi (
        .clk(clk), .rst_n(rst_ni), .we(sel[i] && !run_o && !half),
        .d(bus_wdata[31:16]), .q(hi));
      assign view[i] = {hi, lo};
    end else if (slot_kind(i) == K_HALF) begin : g_hw
      logic [15:0] q;
      dmareg_half #(.W(16), .RST(16'h0)) u_w (
        .clk(clk), .rst_n(rst_ni), .we(sel[i] && !run_o),
        .d(bus_wdata[15:0]), .q(q));
      if (slot_signed(i)) begin : g_sx
        assign view[i] = {{16{q[15]}}, q};
      end else begin : g_zx
        assign view[i] = {16'h0, q};
      end
    end else if (slot_kind(i) == K_CFG) begin : g_cfg
      logic [15:0] q;
      dmareg_half #(.W(16), .RST(16'h0)) u_w (
        .clk(clk), .rst_n(rst_ni), .we(sel[i]),
        .d(bus_wdata[15:0]), .q(q));
      assign view[i] = {16'h0, q};
      assign cfg_o   = q;
    end else if (slot_kind(i) == K_STAT) begin : g_st
      assign view[i] = stat_vec;
    end else if (slot_kind(i) == K_PMAP) begin : g_pm
      logic [15:0] q;
      dmareg_half #(.W(16), .RST(PMAP_RESET)) u_w (
        .clk(clk), .rst_n(rst_ni), .we(sel[i] && !run_o),
        .d({bus_wdata[15:CTYPE_BIT+1], q[CTYPE_BIT], bus_wdata[CTYPE_BIT-1:0]}),
        .q(q));
      assign view[i] = {16'h0, q};
    end else begin : g_rsvd
      assign view[i] = '0;
    end
  end

  // registered response
  logic [31:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (rd_ok) rdata_d = half ? {16'h0, view[slot][15:0]} : view[slot];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= bad;
    end
  end

  // checks
  logic [15:0] xcnt_w, strt_hi_w;
  logic        ctype_w;
  assign xcnt_w    = view[SLOT_XCNT][15:0];
  assign strt_hi_w = view[SLOT_STRT][31:16];
  assign ctype_w   = view[SLOT_PMAP][CTYPE_BIT];

  p_bad_size_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr || bus_rd) && !(bus_size == 3'd2 || bus_size == 3'd4)
    |=> bus_err && (bus_rdata == 32'h0));
  p_rsvd_wr_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_wr && (bus_addr == ADDR_W'(12)) && (bus_size == 3'd4) |=> bus_err);
  p_protect_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    run_o && bus_wr && (bus_addr == ADDR_W'(16)) |=> $stable(xcnt_w) && !bus_err);
  p_ptr_half_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_wr && (bus_size == 3'd2) && (bus_addr == ADDR_W'(4)) |=> $stable(strt_hi_w));
  p_ctype_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> $stable(ctype_w));

endmodule

// File: tb/test_dmareg_chan.sv
`timescale 1ns/1ps
module test_dmareg_chan;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        eng_done, eng_err;
  logic [15:0] cfg_o;
  logic        run_o, start_o, stop_o;

  always #4 clk = ~clk;

  dmareg_chan i_dmareg_chan (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .eng_done(eng_done),
    .eng_err(eng_err), .cfg_o(cfg_o), .run_o(run_o), .start_o(start_o),
    .stop_o(stop_o));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] m [16];
  bit mrun, mdone, merr;

  function automatic bit rsvd(input int s);
    return (s == 3) || (s == 13) || (s == 15);
  endfunction

  function automatic bit is32(input int s);
    return (s == 0) || (s == 1) || (s == 8) || (s == 9);
  endfunction

  function automatic logic [31:0] mview(input int s);
    if (rsvd(s))            return 32'h0;
    if (s == 10)            return {29'h0, mrun, merr, mdone};
    if (is32(s))            return m[s];
    if (s == 5 || s == 7)   return {{16{m[s][15]}}, m[s][15:0]};
    return {16'h0, m[s][15:0]};
  endfunction

  function automatic logic [31:0] pat(input int s);
    return 32'h8765_8000 ^ (32'(s) * 32'h0101_0301);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input int slot, input int sz,
                     input logic [31:0] d, input bit ed, input bit ee,
                     input string tag, input int low = 0);
    logic [31:0] erd, v;
    bit eerr, est, esp, cfgw;
    eerr = !(sz == 2 || sz == 4) || (low != 0) || (wr && rsvd(slot));
    v    = mview(slot);
    erd  = (!wr && !eerr) ? ((sz == 2) ? {16'h0, v[15:0]} : v) : 32'h0;
    est = 0; esp = 0; cfgw = 0;
    if (wr && !eerr) begin
      if (slot == 2) begin
        m[2] = {16'h0, d[15:0]}; mrun = d[0]; est = d[0]; esp = !d[0]; cfgw = 1;
      end else if (slot == 10) begin
        if (d[0]) mdone = 0;
        if (d[1]) merr  = 0;
      end else if (!mrun) begin
        if (is32(slot))      m[slot] = (sz == 4) ? d : {m[slot][31:16], d[15:0]};
        else if (slot == 11) m[11] = {16'h0, d[15:7], m[11][6], d[5:0]};
        else                 m[slot] = {16'h0, d[15:0]};
      end
    end
    if (ed) begin mdone = 1; if (!cfgw) mrun = 0; end
    if (ee) merr = 1;
    @(negedge clk);
    bus_addr  = 6'(slot * 4 + low);
    bus_wr    = wr;
    bus_rd    = !wr;
    bus_size  = 3'(sz);
    bus_wdata = d;
    eng_done  = ed;
    eng_err   = ee;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_done = 0; eng_err = 0; bus_wdata = '0;
    chk(tag, $sformatf("err slot %0d size %0d", slot, sz), 32'(bus_err), 32'(eerr));
    chk(tag, $sformatf("rdata slot %0d size %0d", slot, sz), bus_rdata, erd);
    chk(tag, "run", 32'(run_o), 32'(mrun));
    chk(tag, "start pulse", 32'(start_o), 32'(est));
    chk(tag, "stop pulse", 32'(stop_o), 32'(esp));
    chk(tag, "cfg_o", 32'(cfg_o), m[2]);
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_size = '0;
    bus_wdata = '0; eng_done = 0; eng_err = 0;
    for (int s = 0; s < 16; s++) m[s] = 32'h0;
    m[11] = 32'h0040; mrun = 0; mdone = 0; merr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: outputs after reset
    chk("R1", "bus_err", 32'(bus_err), 0);
    chk("R1", "bus_rdata", bus_rdata, 0);
    chk("R1", "run", 32'(run_o), 0);
    chk("R1", "start", 32'(start_o), 0);
    chk("R1", "stop", 32'(stop_o), 0);
    chk("R1", "cfg_o", 32'(cfg_o), 0);
    for (int s = 0; s < 16; s++) acc(0, s, 4, 0, 0, 0, "R1");

    // R2 / R3: read sweep over all slots and sizes
    for (int s = 0; s < 16; s++)
      for (int sz = 0; sz < 8; sz++)
        acc(0, s, sz, 0, 0, 0, (sz == 2 || sz == 4) ? "R3" : "R2");
    acc(0, 4, 4, 0, 0, 0, "R2", 2);
    acc(1, 4, 4, 32'h1111, 0, 0, "R2", 1);
    acc(0, 4, 4, 0, 0, 0, "R2");

    // R5 / R4 / R9 / R13: idle writes to every slot, then read back
    for (int s = 0; s < 16; s++) begin
      if (s == 2 || s == 10) continue;
      acc(1, s, 4, pat(s), 0, 0, rsvd(s) ? "R4" : (s == 11) ? "R9" : "R5");
    end
    for (int s = 0; s < 16; s++) begin
      acc(0, s, 4, 0, 0, 0, (s == 5 || s == 7) ? "R13" : "R5");
      acc(0, s, 2, 0, 0, 0, "R3");
    end
    acc(1, 11, 4, 32'hFFFF_FFFF, 0, 0, "R9");
    acc(0, 11, 4, 0, 0, 0, "R9");
    acc(1, 11, 2, 32'h0, 0, 0, "R9");
    acc(0, 11, 4, 0, 0, 0, "R9");

    // R7: half writes to 32-bit slots
    for (int s = 0; s < 10; s++) begin
      if (!is32(s)) continue;
      acc(1, s, 2, 32'hFFFF_1234 + 32'(s), 0, 0, "R7");
      acc(0, s, 4, 0, 0, 0, "R7");
    end

    // R2: illegal-size writes leave state untouched
    for (int sz = 0; sz < 8; sz++) begin
      if (sz == 2 || sz == 4) continue;
      acc(1, 4, sz, 32'h5555_5555, 0, 0, "R2");
      acc(0, 4, 4, 0, 0, 0, "R2");
    end

    // R10: launch
    acc(1, 2, 2, 32'h0000_0081, 0, 0, "R10");
    acc(0, 10, 4, 0, 0, 0, "R8");

    // R6: protected while running
    for (int s = 0; s < 16; s++) begin
      if (s == 2 || s == 10 || rsvd(s)) continue;
      acc(1, s, 4, 32'hDEAD_BEEF, 0, 0, "R6");
      acc(0, s, 4, 0, 0, 0, "R6");
    end
    acc(1, 2, 4, 32'h0000_0003, 0, 0, "R10");

    // R12: engine events
    acc(0, 0, 4, 0, 1, 0, "R12");
    acc(0, 10, 4, 0, 0, 0, "R12");
    acc(0, 0, 4, 0, 0, 1, "R12");
    acc(0, 10, 4, 0, 0, 0, "R12");

    // R8: write-1-to-clear
    acc(1, 10, 2, 32'h0000_0006, 0, 0, "R8");
    acc(0, 10, 4, 0, 0, 0, "R8");
    acc(1, 2, 2, 32'h1, 0, 0, "R10");
    acc(1, 10, 4, 32'hFFFF_FFFF, 0, 0, "R8");
    acc(0, 10, 4, 0, 0, 0, "R8");

    // R12: set beats clear, control write beats done
    acc(1, 10, 2, 32'h1, 1, 1, "R12");
    acc(0, 10, 4, 0, 0, 0, "R12");
    acc(1, 2, 2, 32'h1, 1, 0, "R12");
    acc(0, 10, 4, 0, 0, 0, "R12");

    // R11: halt, then parameters are writable again
    acc(1, 2, 2, 32'h0000_00F0, 0, 0, "R11");
    acc(0, 10, 4, 0, 0, 0, "R11");
    acc(1, 4, 4, 32'h0000_1357, 0, 0, "R6");
    acc(0, 4, 4, 0, 0, 0, "R6");
    acc(0, 0, 4, 0, 0, 0, "R11");

    finished = 1;
    summary();
    $finish;
  end

endmodule